// File: doc/BRIEF.md
# Multiprocessor 9-bit UART Controller

A full-duplex asynchronous serial port driven through one byte-wide control/status register and one data register. A two-bit mode field picks the frame format: 8 data bits, or 9 data bits where the ninth bit comes from a control bit on transmit and is captured into a status bit on receive. With the 8-bit format the received stop bit goes into that status bit instead. Transmit-done and receive-done flags are set by hardware and stay set until software writes them to 0. Their OR drives the interrupt output.

A multiprocessor enable lets a receiver on a shared bus ignore traffic meant for other nodes. In the 9-bit formats only frames whose ninth bit is 1 (address frames) are accepted. In the 8-bit format only frames with a valid stop bit are accepted. The bit rate comes from an external 16x oversampling tick. Register access is a simple single-cycle write port with a combinational read.

Top module: `mpuart_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the receive buffer (address 1) reads 0x00, `txd` is high and `irq` is low. Control bit positions are: [7:6] mode, [5] multiprocessor enable, [4] receive enable, [3] transmit ninth bit, [2] received ninth/stop bit, [1] transmit-done flag, [0] receive-done flag.
- R2: With mode 00, a data write sends nothing, `txd` stays high, no flag is set, and no frame is received.
- R3: A write to address 1 in modes 01, 10 or 11 sends a frame of 16 ticks per bit: start bit 0, then 8 data bits LSB first. In modes 10 and 11 a ninth bit equal to control bit [3] follows. The frame ends with stop bit 1.
- R4: A data write made while a frame is being sent is ignored: the frame in flight is unchanged and no second frame follows.
- R5: The transmit-done flag [1] is set when the stop bit ends. It stays set until software writes it to 0.
- R6: A received frame that is accepted sets the receive-done flag [0] and loads the data into the buffer. It loads control bit [2] with the ninth bit in modes 10/11, or with the stop bit in mode 01. The flag stays set until software writes it to 0.
- R7: While the receive enable [4] is 0, no frame is received and the buffer and flags are left unchanged.
- R8: In modes 10/11 with the multiprocessor enable [5] set, a frame whose ninth bit is 0 is discarded. It does not set the flag and does not change the buffer or bit [2].
- R9: In mode 01 with the multiprocessor enable set, a frame whose stop bit is 0 is discarded. With the enable clear, the frame is accepted and bit [2] reads 0.
- R10: A low pulse on `rxd` shorter than half a bit is rejected as a glitch. The receiver then accepts the next valid frame.
- R11: `irq` is high exactly when flag [1] or flag [0] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable, 16 per bit time |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control/status, 1 = data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Interrupt, OR of the two done flags |

## Verification
Random frames run in loopback with random mode, ninth bit, multiprocessor enable and data. This separates the two ninth-bit sources (control bit versus stop bit) and the accept and discard paths of the filter in one sweep. Directed frames drive `rxd` directly with a stop bit of 0, a ninth bit of 0, and a short low glitch. These are the cases that loopback cannot produce, and they tell apart the 8-bit filter, the 9-bit filter and glitch rejection. A second data write made mid-frame, and a frame sent in mode 00, show that ignored stimulus leaves the line and the flags untouched.

// File: rtl/mpuart_pkg.sv
// Shared constants and types for the multiprocessor UART.
// Assumes: the mode field encoding is fixed by the register layout.
package mpuart_pkg;
    localparam logic [1:0] MODE_OFF = 2'b00;
    localparam logic [1:0] MODE_8B  = 2'b01;

    // Control register bit positions.
    localparam int B_MODE_HI = 7;
    localparam int B_MODE_LO = 6;
    localparam int B_MPEN    = 5;
    localparam int B_REN     = 4;
    localparam int B_TB9     = 3;
    localparam int B_RB9     = 2;
    localparam int B_TDONE   = 1;
    localparam int B_RDONE   = 0;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/mpuart_sync.sv
// Input synchronizer for the asynchronous receive line.
// Assumes: STAGES >= 1; resets to the idle (high) line level.
module mpuart_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 1) begin : g_one
            logic r;
            // Single retiming flop.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= 1'b1;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] r;
            // Shift the line through a flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= '1;
                else        r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mpuart_tx.sv
// Transmit shift engine: sends start, 8 data bits LSB first, an optional
// ninth bit and a stop bit, OVS ticks per bit.
// Assumes: start is only honoured while idle; ninth bit is latched at start.
module mpuart_tx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic       nine,
    input  logic       bit9,
    input  logic [7:0] data,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int FW = 11;

    logic [FW-1:0] frame;
    logic [TW-1:0] tcnt;
    logic [3:0]    bidx;
    logic [3:0]    last;

    // Load a frame on start, then shift one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '1;
            tcnt  <= '0;
            bidx  <= '0;
            last  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    frame <= nine ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
                    last  <= nine ? 4'd10 : 4'd9;
                    busy  <= 1'b1;
                    tcnt  <= '0;
                    bidx  <= '0;
                end
            end else if (tick) begin
                if (tcnt == TW'(OVS - 1)) begin
                    tcnt <= '0;
                    if (bidx == last) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        frame <= {1'b1, frame[FW-1:1]};
                        bidx  <= bidx + 4'd1;
                    end
                end else begin
                    tcnt <= tcnt + TW'(1);
                end
            end
        end
    end

    // Line is high whenever no frame is in flight.
    assign txd = busy ? frame[0] : 1'b1;
endmodule

// File: rtl/mpuart_rx.sv
// Receive shift engine: finds a falling edge, confirms the start bit at
// mid-bit, samples data, optional ninth bit and stop bit at mid-bit.
// Assumes: rxd is already synchronized; en low aborts any frame.
module mpuart_rx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       nine,
    input  logic       rxd,
    output logic       busy,
    output logic       done,
    output logic [7:0] data,
    output logic       bit9,
    output logic       stop
);
    import mpuart_pkg::*;

    localparam int TW   = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int HALF = OVS / 2;

    rx_state_e     st;
    logic          prev;
    logic [TW-1:0] tcnt;
    logic [3:0]    bidx;
    logic [8:0]    sh;
    logic [3:0]    last;

    // Index of the final data bit for the active format.
    always_comb last = nine ? 4'd8 : 4'd7;

    // Frame state machine with mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            prev <= 1'b1;
            tcnt <= '0;
            bidx <= '0;
            sh   <= '0;
            done <= 1'b0;
            data <= '0;
            bit9 <= 1'b0;
            stop <= 1'b0;
        end else begin
            prev <= rxd;
            done <= 1'b0;
            if (!en) begin
                st <= RX_IDLE;
            end else begin
                case (st)
                    RX_IDLE: begin
                        tcnt <= '0;
                        if (prev && !rxd) st <= RX_START;
                    end
                    RX_START: if (tick) begin
                        if (tcnt == TW'(HALF - 1)) begin
                            tcnt <= '0;
                            bidx <= '0;
                            st   <= rxd ? RX_IDLE : RX_BITS;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                    RX_BITS: if (tick) begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt <= '0;
                            sh   <= {rxd, sh[8:1]};
                            if (bidx == last) st <= RX_STOP;
                            else              bidx <= bidx + 4'd1;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                    RX_STOP: if (tick) begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt <= '0;
                            stop <= rxd;
                            data <= nine ? sh[7:0] : sh[8:1];
                            bit9 <= sh[8];
                            done <= 1'b1;
                            st   <= RX_IDLE;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    assign busy = (st != RX_IDLE);
endmodule

// File: rtl/mpuart_top.sv
// Multiprocessor UART: control/status register, data register, transmit
// and receive engines, address filter and interrupt.
// Assumes: baud_tick pulses OVS times per bit; reg port is single-cycle.
module mpuart_top #(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    import mpuart_pkg::*;

    logic [1:0] mode;
    logic       mp_en, ren, tb9, rb9, tdone, rdone;
    logic [7:0] rx_buf;

    logic wr_ctrl, wr_data, nine, tx_start, tx_busy, tx_done;
    logic rxd_s, rx_en, rx_busy, rx_done, rx_bit9, rx_stop, rx_acc;
    logic [7:0] rx_data;

    // Register port decode and frame format.
    always_comb begin
        wr_ctrl  = reg_wr && !reg_addr;
        wr_data  = reg_wr &&  reg_addr;
        nine     = mode[1];
        tx_start = wr_data && (mode != MODE_OFF) && !tx_busy;
        rx_en    = ren && (mode != MODE_OFF);
    end

    // Address filter: decide whether a completed frame is kept.
    always_comb begin
        if (nine) rx_acc = rx_done && (!mp_en || rx_bit9);
        else      rx_acc = rx_done && (!mp_en || rx_stop);
    end

    mpuart_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
    );

    mpuart_tx #(.OVS(OVS)) i_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_start),
        .nine(nine), .bit9(tb9), .data(reg_wdata),
        .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    mpuart_rx #(.OVS(OVS)) i_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_en),
        .nine(nine), .rxd(rxd_s), .busy(rx_busy), .done(rx_done),
        .data(rx_data), .bit9(rx_bit9), .stop(rx_stop)
    );

    // Control register: software write, then hardware updates win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_OFF;
            mp_en  <= 1'b0;
            ren    <= 1'b0;
            tb9    <= 1'b0;
            rb9    <= 1'b0;
            tdone  <= 1'b0;
            rdone  <= 1'b0;
            rx_buf <= '0;
        end else begin
            if (wr_ctrl) begin
                mode  <= reg_wdata[B_MODE_HI:B_MODE_LO];
                mp_en <= reg_wdata[B_MPEN];
                ren   <= reg_wdata[B_REN];
                tb9   <= reg_wdata[B_TB9];
                rb9   <= reg_wdata[B_RB9];
                tdone <= reg_wdata[B_TDONE];
                rdone <= reg_wdata[B_RDONE];
            end
            if (tx_done) tdone <= 1'b1;
            if (rx_acc) begin
                rdone  <= 1'b1;
                rb9    <= nine ? rx_bit9 : rx_stop;
                rx_buf <= rx_data;
            end
        end
    end

    // Read mux and interrupt.
    assign reg_rdata = reg_addr ? rx_buf : {mode, mp_en, ren, tb9, rb9, tdone, rdone};
    assign irq       = tdone | rdone;
endmodule

// File: rtl/mpuart_chk.sv
// Assertion checker for mpuart_top, attached with bind.
// Assumes: signals are sampled at the top's clock with synchronous reset.
module mpuart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic [1:0] mode,
    input logic       mp_en,
    input logic       ren,
    input logic       tdone,
    input logic       rdone,
    input logic [7:0] rx_buf,
    input logic       wr_ctrl,
    input logic [7:0] reg_wdata,
    input logic       tx_busy,
    input logic       tx_done,
    input logic       rx_busy,
    input logic       rx_done,
    input logic       rx_acc,
    input logic       rx_bit9,
    input logic       rx_stop
);
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd); // R3
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(txd)); // R3
    AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !tx_busy) |=> !tx_busy); // R2
    AST_TDONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdone) |-> $past(tx_done || (wr_ctrl && reg_wdata[1]))); // R5
    AST_RDONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdone) |-> $past(rx_acc || (wr_ctrl && reg_wdata[0]))); // R6
    AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ren |=> !rx_busy); // R7
    AST_MP_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && mode[1] && mp_en && !rx_bit9 && !wr_ctrl)
        |=> ($stable(rdone) && $stable(rx_buf))); // R8
    AST_STOP_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && mode == 2'b01 && mp_en && !rx_stop && !wr_ctrl)
        |=> ($stable(rdone) && $stable(rx_buf))); // R9
endmodule

bind mpuart_top mpuart_chk i_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .mode(mode), .mp_en(mp_en),
    .ren(ren), .tdone(tdone), .rdone(rdone), .rx_buf(rx_buf),
    .wr_ctrl(wr_ctrl), .reg_wdata(reg_wdata), .tx_busy(tx_busy),
    .tx_done(tx_done), .rx_busy(rx_busy), .rx_done(rx_done),
    .rx_acc(rx_acc), .rx_bit9(rx_bit9), .rx_stop(rx_stop)
);

// File: tb/test_mpuart_top.sv
module test_mpuart_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rxd, txd, irq;
    logic       rxd_drv = 1'b1;
    logic       loop = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int tlow = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign rxd = loop ? txd : rxd_drv;

    mpuart_top i_mpuart_top (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    always @(negedge clk) begin
        cyc++;
        if (!txd) tlow++;
    end

    // Watchdog.
    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic nine, input logic b9, input logic stp);
        @(negedge clk);
        rxd_drv = 1'b0; idle(16);
        for (int i = 0; i < 8; i++) begin rxd_drv = d[i]; idle(16); end
        if (nine) begin rxd_drv = b9; idle(16); end
        rxd_drv = stp; idle(16);
        rxd_drv = 1'b1; idle(16);
    endtask

    task automatic capture_tx(input logic nine, output logic [7:0] d, output logic b9,
                              output logic stp, output logic seen);
        int w = 0;
        d = '0; b9 = 1'b0; stp = 1'b0; seen = 1'b0;
        while (txd && w < 100) begin @(negedge clk); w++; end
        if (!txd) begin
            seen = 1'b1;
            idle(7);
            for (int i = 0; i < 8; i++) begin idle(16); d[i] = txd; end
            if (nine) begin idle(16); b9 = txd; end
            idle(16); stp = txd;
        end
    endtask

    // Expected acceptance under the address filter (R8, R9).
    function automatic logic exp_accept(input logic [1:0] m, input logic mp,
                                        input logic b9, input logic stp);
        if (m[1]) return !mp || b9;
        return !mp || stp;
    endfunction

    logic [7:0] v, d;
    logic b9, stp, seen;
    logic [7:0] exp_buf;
    logic exp_rb9;

    initial begin
        void'($urandom(32'h1A2B3C4D));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(1'b0, v); chk("R1 ctrl reset", v, 8'h00);
        rd(1'b1, v); chk("R1 rx buffer reset", v, 8'h00);
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 irq low", irq, 1'b0);

        // R2 mode 00 quiet
        wr(1'b0, 8'h10);
        begin
            int mark = tlow;
            wr(1'b1, 8'h55);
            idle(200);
            chk("R2 no tx in mode 00", tlow, mark);
        end
        send_frame(8'h66, 1'b0, 1'b0, 1'b1);
        idle(10);
        rd(1'b0, v); chk("R2 no flags in mode 00", v, 8'h10);

        // R7 receive disabled
        wr(1'b0, 8'h40);
        send_frame(8'h77, 1'b0, 1'b0, 1'b1);
        idle(10);
        rd(1'b0, v); chk("R7 no rdone when disabled", v[0], 1'b0);
        rd(1'b1, v); chk("R7 buffer unchanged", v, 8'h00);

        // R10 glitch rejection then recovery
        wr(1'b0, 8'h50);
        @(negedge clk); rxd_drv = 1'b0; idle(4); rxd_drv = 1'b1;
        idle(100);
        rd(1'b0, v); chk("R10 glitch ignored", v[0], 1'b0);
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
        idle(10);
        rd(1'b0, v); chk("R10 frame after glitch rdone", v[0], 1'b1);
        chk("R6 mode 01 bit2 = stop", v[2], 1'b1);
        rd(1'b1, v); chk("R6 buffer data", v, 8'h5A);
        chk("R11 irq with rdone", irq, 1'b1);
        wr(1'b0, 8'h50);
        chk("R11 irq cleared", irq, 1'b0);
        rd(1'b0, v); chk("R6 flag cleared by write", v, 8'h50);

        // R9 mode 01 stop bit 0, filter off: accepted with bit2 = 0
        send_frame(8'h3C, 1'b0, 1'b0, 1'b0);
        idle(10);
        rd(1'b0, v); chk("R9 bad stop kept, filter off", v[0], 1'b1);
        chk("R9 bit2 holds stop 0", v[2], 1'b0);
        rd(1'b1, v); chk("R9 buffer 3C", v, 8'h3C);

        // R9 filter on, stop 0 discarded
        wr(1'b0, 8'h70);
        send_frame(8'hC3, 1'b0, 1'b0, 1'b0);
        idle(10);
        rd(1'b0, v); chk("R9 bad stop discarded", v[0], 1'b0);
        rd(1'b1, v); chk("R9 buffer unchanged", v, 8'h3C);
        send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
        idle(10);
        rd(1'b0, v); chk("R9 good stop accepted", v[0], 1'b1);
        rd(1'b1, v); chk("R9 buffer C3", v, 8'hC3);

        // R8 9-bit with filter: ninth 0 discarded, ninth 1 accepted
        wr(1'b0, 8'hF0);
        send_frame(8'h99, 1'b1, 1'b0, 1'b1);
        idle(10);
        rd(1'b0, v); chk("R8 data frame discarded", v[0], 1'b0);
        chk("R8 bit2 unchanged", v[2], 1'b0);
        rd(1'b1, v); chk("R8 buffer unchanged", v, 8'hC3);
        send_frame(8'h99, 1'b1, 1'b1, 1'b1);
        idle(10);
        rd(1'b0, v); chk("R8 address frame accepted", v[0], 1'b1);
        chk("R6 bit2 = ninth bit", v[2], 1'b1);
        rd(1'b1, v); chk("R8 buffer 99", v, 8'h99);

        // R4 write during busy ignored, R5 sticky done flag
        wr(1'b0, 8'h88);
        wr(1'b1, 8'hA5);
        fork
            capture_tx(1'b1, d, b9, stp, seen);
            begin idle(40); wr(1'b1, 8'h11); end
        join
        chk("R3 frame seen", seen, 1'b1);
        chk("R4 data of first write kept", d, 8'hA5);
        chk("R3 ninth bit from control", b9, 1'b1);
        chk("R3 stop bit high", stp, 1'b1);
        begin
            int mark;
            idle(12);
            mark = tlow;
            idle(300);
            chk("R4 no second frame", tlow, mark);
        end
        rd(1'b0, v); chk("R5 tdone sticky", v[1], 1'b1);
        chk("R11 irq with tdone", irq, 1'b1);
        wr(1'b0, 8'h80);
        rd(1'b0, v); chk("R5 tdone cleared", v[1], 1'b0);

        // Random loopback frames (R3, R5, R6, R8, R9)
        exp_buf = 8'h99;
        exp_rb9 = 1'b0;
        loop = 1'b1;
        for (int it = 0; it < 24; it++) begin
            logic [1:0] m;
            logic mp, tb;
            logic [7:0] dat;
            logic acc;
            m   = 2'(1 + ($urandom % 3));
            mp  = 1'($urandom % 2);
            tb  = 1'($urandom % 2);
            dat = 8'($urandom);
            wr(1'b0, {m, mp, 1'b1, tb, exp_rb9, 2'b00});
            wr(1'b1, dat);
            capture_tx(m[1], d, b9, stp, seen);
            chk("R3 random frame data", d, dat);
            if (m[1]) chk("R3 random ninth bit", b9, tb);
            chk("R3 random stop", stp, 1'b1);
            idle(30);
            acc = exp_accept(m, mp, tb, 1'b1);
            if (acc) begin
                exp_buf = dat;
                exp_rb9 = m[1] ? tb : 1'b1;
            end
            rd(1'b0, v);
            chk("R5 random tdone", v[1], 1'b1);
            chk("R6 R8 random rdone", v[0], acc);
            chk("R6 random bit2", v[2], exp_rb9);
            rd(1'b1, v); chk("R6 R8 random buffer", v, exp_buf);
            wr(1'b0, {m, mp, 1'b1, tb, exp_rb9, 2'b00});
            chk("R11 random irq cleared", irq, 1'b0);
        end
        loop = 1'b0;

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule